// File: doc/BRIEF.md
# Speed-Mode Wait State Generator

This block produces the active-low wait request for an 8-bit CPU with a Z80-style bus. It watches the memory request, I/O request, opcode-fetch (M1) and refresh strobes and a three-position speed setting: normal, middle or fast. From these it decides whether the current bus cycle needs an extra wait state. When one is needed, it pulls the wait line low for a fixed number of CPU clocks and then releases it. It requests at most one wait per bus cycle.

The block is clocked by whichever clock is currently driving the CPU, so one wait lasts one fast or one slow period. It samples the bus on the falling clock edge. In the faster modes it also stretches every I/O cycle. This gives a slower downstream clock controller time to see the I/O request before the cycle ends. Memory cycles wait on opcode fetches only in normal mode, and on every non-refresh access in the other two modes.

Top module: `wait_state_gen`

## Requirements
- R1: While `rst_n` is low, `wait_n` is high.
- R2: In normal mode (`speed_sel` = 3'b001), a wait is requested only for a memory request with M1 active and refresh inactive. A plain memory access and an I/O request get no wait.
- R3: In middle mode (`speed_sel` = 3'b010) and fast mode (3'b100), every memory request with refresh inactive requests a wait, whether or not M1 is active.
- R4: In middle and fast mode, an active I/O request also requests a wait.
- R5: A memory request made while refresh is active never requests a wait, in any mode.
- R6: Any other value of `speed_sel` (none or more than one bit set) behaves as normal mode.
- R7: Once started, `wait_n` stays low for exactly WAIT_CYCLES falling-edge samples (default 1) and then returns high.
- R8: At most one wait is issued per bus cycle. A bus cycle ends at a falling edge where both `mreq_n` and `iorq_n` are high.
- R9: After reset is released, no wait is issued until one idle sample (both `mreq_n` and `iorq_n` high) has been seen.
- R10: `wait_n` goes low right after the falling edge at which a qualifying request is first sampled, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Currently selected CPU clock; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode-fetch cycle marker, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| speed_sel | input | 3 | Speed switch lines: bit0 normal, bit1 middle, bit2 fast; one-hot, anything else counts as normal |
| wait_n | output | 1 | Wait request to the CPU, active low |

## Verification
A stale per-cycle flag shows up in one of two ways at the ports. Either a second low pulse appears inside the same bus cycle, or an expected pulse goes missing in the next cycle, one falling edge after the strobe is sampled. A wrong length count shows as a `wait_n` low window longer or shorter than WAIT_CYCLES edges. A wrong mode decode shows as a pulse where none is due, or none where one is due, during an M1-less memory access or an I/O access. A wrong arming state after reset shows as a pulse during the bus cycle that was already in progress when reset was released.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   typedef enum logic [1:0] {
      SPD_NORMAL = 2'd0,
      SPD_MIDDLE = 2'd1,
      SPD_FAST   = 2'd2
   } speed_t;

   typedef struct packed {
      logic mem;
      logic io;
      logic fetch;
      logic refresh;
   } bus_req_t;
endpackage

// File: rtl/wsg_mode_decode.sv
module wsg_mode_decode
   import wsg_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] speed_sel,
   output speed_t           speed
);
   localparam logic [SEL_W-1:0] SEL_MID  = SEL_W'(2);
   localparam logic [SEL_W-1:0] SEL_FAST = SEL_W'(4);

   // Only clean one-hot codes leave normal mode; every other code falls back to normal
   always_comb begin
      case (speed_sel)
         SEL_MID:  speed = SPD_MIDDLE;
         SEL_FAST: speed = SPD_FAST;
         default:  speed = SPD_NORMAL;
      endcase
   end
endmodule

// File: rtl/wsg_request.sv
module wsg_request
   import wsg_pkg::*;
(
   input  speed_t   speed,
   input  bus_req_t bus,
   output logic     need_wait,
   output logic     idle
);
   logic boost;

   always_comb begin
      boost     = (speed != SPD_NORMAL);
      need_wait = (bus.mem & ~bus.refresh & (bus.fetch | boost))
                | (bus.io & boost);
      idle      = ~bus.mem & ~bus.io;
   end
endmodule

// File: rtl/wsg_pulse.sv
module wsg_pulse #(
   parameter int WAIT_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic need_wait,
   input  logic idle,
   output logic wait_n
);
   localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);

   logic armed;
   logic served;
   logic busy;
   logic start;

   assign start = armed & ~served & ~busy & ~idle & need_wait;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         served <= 1'b0;
      end else if (idle) begin
         armed  <= 1'b1;
         served <= 1'b0;
      end else if (start) begin
         served <= 1'b1;
      end
   end

   generate
      if (WAIT_CYCLES < 1) begin : g_bad_len
         $error("wsg_pulse: WAIT_CYCLES must be at least 1");
      end else if (WAIT_CYCLES == 1) begin : g_single
         logic hold;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) hold <= 1'b0;
            else        hold <= start;
         end
         assign busy = hold;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (start)         cnt <= CW'(WAIT_CYCLES);
            else if (cnt != '0)     cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);
      end
   endgenerate

   assign wait_n = ~busy;
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
   import wsg_pkg::*;
#(
   parameter int WAIT_CYCLES = 1,
   parameter int SEL_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mreq_n,
   input  logic             iorq_n,
   input  logic             m1_n,
   input  logic             rfsh_n,
   input  logic [SEL_W-1:0] speed_sel,
   output logic             wait_n
);
   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("wait_state_gen: SEL_W must be 3");
      end
   endgenerate

   speed_t   speed;
   bus_req_t bus;
   logic     need_wait;
   logic     idle;

   assign bus.mem     = ~mreq_n;
   assign bus.io      = ~iorq_n;
   assign bus.fetch   = ~m1_n;
   assign bus.refresh = ~rfsh_n;

   wsg_mode_decode #(.SEL_W(SEL_W)) u_dec (
      .speed_sel (speed_sel),
      .speed     (speed)
   );

   wsg_request u_req (
      .speed     (speed),
      .bus       (bus),
      .need_wait (need_wait),
      .idle      (idle)
   );

   wsg_pulse #(.WAIT_CYCLES(WAIT_CYCLES)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .need_wait (need_wait),
      .idle      (idle),
      .wait_n    (wait_n)
   );
endmodule

// File: rtl/wait_state_gen_chk.sv
module wait_state_gen_chk #(
   parameter int WAIT_CYCLES = 1,
   parameter int SEL_W       = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mreq_n,
   input logic             iorq_n,
   input logic             m1_n,
   input logic             rfsh_n,
   input logic [SEL_W-1:0] speed_sel,
   input logic             wait_n
);
   logic boost;
   logic req;
   logic idle_s;
   logic seen_idle;
   logic waited;
   logic [31:0] low_cnt;

   assign boost  = (speed_sel == SEL_W'(2)) || (speed_sel == SEL_W'(4));
   assign req    = (!mreq_n && rfsh_n && (!m1_n || boost)) || (!iorq_n && boost);
   assign idle_s = mreq_n && iorq_n;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_idle <= 1'b0;
         waited    <= 1'b0;
         low_cnt   <= '0;
      end else begin
         if (idle_s) seen_idle <= 1'b1;
         if (idle_s)       waited <= 1'b0;
         else if (!wait_n) waited <= 1'b1;
         low_cnt <= wait_n ? '0 : low_cnt + 1;
      end
   end

   assert_idle_in_reset_R1: assert property (@(negedge clk) !rst_n |-> wait_n);

   assert_start_needs_request_R10: assert property (@(negedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> $past(req));

   assert_no_refresh_wait_R5: assert property (@(negedge clk) disable iff (!rst_n)
      $fell(wait_n) && $past(iorq_n) |-> $past(rfsh_n));

   assert_pulse_length_R7: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(wait_n) |-> (low_cnt == WAIT_CYCLES));

   assert_pulse_bounded_R7: assert property (@(negedge clk) disable iff (!rst_n)
      low_cnt <= WAIT_CYCLES);

   assert_once_per_cycle_R8: assert property (@(negedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> !waited);

   assert_armed_after_idle_R9: assert property (@(negedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> seen_idle);
endmodule

bind wait_state_gen wait_state_gen_chk #(.WAIT_CYCLES(WAIT_CYCLES), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mreq_n    (mreq_n),
   .iorq_n    (iorq_n),
   .m1_n      (m1_n),
   .rfsh_n    (rfsh_n),
   .speed_sel (speed_sel),
   .wait_n    (wait_n)
);

// File: tb/sim_wait_state_gen.sv
`timescale 1ns/1ps
module sim_wait_state_gen;
   localparam int WAIT_CYCLES = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rfsh_n = 1'b1;
   logic [2:0] speed_sel = 3'b001;
   logic       wait_n;

   int tests = 0;
   int fails = 0;
   logic done_flag = 1'b0;

   int  m_cnt = 0;
   bit  m_armed = 0;
   bit  m_served = 0;

   always #10 clk = ~clk;

   wait_state_gen #(.WAIT_CYCLES(WAIT_CYCLES)) u0 (
      .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
      .m1_n(m1_n), .rfsh_n(rfsh_n), .speed_sel(speed_sel), .wait_n(wait_n)
   );

   function automatic bit want(logic [2:0] sel, bit mem, bit io, bit fetch, bit refr);
      bit fastish = (sel == 3'b010) || (sel == 3'b100);
      return (mem && !refr && (fetch || fastish)) || (io && fastish);
   endfunction

   task automatic check(string tag, logic exp);
      tests++;
      if (wait_n !== exp) begin
         fails++;
         $display("FAIL %s: wait_n=%b expected %b at %0t", tag, wait_n, exp, $time);
      end
   endtask

   // drive at rising edge, model at falling edge, compare just after it
   task automatic step(bit mem, bit io, bit fetch, bit refr, logic [2:0] sel, string tag);
      bit idle, start;
      @(posedge clk);
      mreq_n <= !mem; iorq_n <= !io; m1_n <= !fetch; rfsh_n <= !refr; speed_sel <= sel;
      @(negedge clk);
      idle  = !mem && !io;
      start = !idle && m_armed && !m_served && (m_cnt == 0) && want(sel, mem, io, fetch, refr);
      if (m_cnt != 0) m_cnt--;
      if (idle) begin m_armed = 1; m_served = 0; end
      else if (start) begin m_served = 1; m_cnt = WAIT_CYCLES; end
      #1;
      check(tag, (m_cnt == 0));
   endtask

   initial begin
      #400000;
      if (!done_flag) begin
         tests++; fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state, with a qualifying request on the bus
      mreq_n = 1'b0; m1_n = 1'b0;
      repeat (3) begin
         @(negedge clk); #1;
         check("R1 reset", 1'b1);
      end
      @(posedge clk); rst_n <= 1'b1;
      // R9: bus cycle already running at release gets no wait
      step(1, 0, 1, 0, 3'b001, "R9 no wait before idle");
      step(1, 0, 1, 0, 3'b001, "R9 no wait before idle");
      step(0, 0, 0, 0, 3'b001, "R9 idle");
      // R2 / R10 / R7 / R8: opcode fetch in normal mode
      step(1, 0, 1, 0, 3'b001, "R10 fetch wait starts");
      step(1, 0, 1, 0, 3'b001, "R7 wait released");
      step(1, 0, 1, 0, 3'b001, "R8 no second wait");
      step(0, 0, 0, 0, 3'b001, "idle");
      // R2: plain memory access in normal mode
      step(1, 0, 0, 0, 3'b001, "R2 memory read no wait");
      step(0, 0, 0, 0, 3'b001, "idle");
      // R2: I/O in normal mode
      step(0, 1, 0, 0, 3'b001, "R2 io no wait in normal");
      step(0, 0, 0, 0, 3'b001, "idle");
      // R3: middle mode memory read without M1
      step(1, 0, 0, 0, 3'b010, "R3 middle memory wait");
      step(1, 0, 0, 0, 3'b010, "R7 released");
      step(0, 0, 0, 0, 3'b010, "idle");
      // R5: refresh in fast mode
      step(1, 0, 0, 1, 3'b100, "R5 refresh no wait");
      step(0, 0, 0, 0, 3'b100, "idle");
      // R4: I/O in fast mode
      step(0, 1, 0, 0, 3'b100, "R4 fast io wait");
      step(0, 1, 0, 0, 3'b100, "R8 io single wait");
      step(0, 0, 0, 0, 3'b100, "idle");
      // R6: invalid encodings act as normal
      step(1, 0, 0, 0, 3'b110, "R6 invalid code no memory wait");
      step(0, 0, 0, 0, 3'b110, "idle");
      step(0, 1, 0, 0, 3'b000, "R6 zero code no io wait");
      step(0, 0, 0, 0, 3'b000, "idle");
      step(1, 0, 1, 0, 3'b111, "R6 invalid code fetch waits");
      step(0, 0, 0, 0, 3'b111, "idle");
      // random traffic against the bench model
      begin
         int seed = 32'h5eed;
         logic [2:0] sel = 3'b001;
         void'($urandom(seed));
         for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 8;
            if ($urandom % 16 == 0) sel = 3'($urandom);
            case (r)
               0, 1: step(0, 0, 0, 0, sel, "R10 random idle");
               2:    step(1, 0, 1, 0, sel, "R2 random fetch");
               3:    step(1, 0, 0, 0, sel, "R3 random memory");
               4:    step(1, 0, 0, 1, sel, "R5 random refresh");
               5:    step(0, 1, 0, 0, sel, "R4 random io");
               default: step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                             sel, "R8 random mix");
            endcase
         end
      end
      // R1 again: assert reset mid-wait
      step(0, 0, 0, 0, 3'b010, "idle");
      step(1, 0, 0, 0, 3'b010, "R3 wait before reset");
      @(posedge clk); rst_n <= 1'b0;
      #1; check("R1 reset clears wait", 1'b1);
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule